// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion for an on-chip 10-bit ADC. Software asks for a conversion with a one-clock GO pulse. The block then disconnects the hold capacitor from the input by dropping `sample_en`. It walks a trial code on `dac_code` from the top bit down, one bit for each conversion-clock period, and keeps or drops each bit according to an external comparator. When the last bit is settled, it writes the finished code into `result`, raises the interrupt flag and drops the busy indication. The capacitor is reconnected to the input on the next fourth phase of the four-phase instruction cycle.

Two sources can pace the conversion clock. The first is a divider on the system clock, set by a 2-bit select. The second is a pulse stream `rc_tick`, which carries the edges of a free-running internal RC oscillator, already brought into the `clk` domain. With the RC source, the block waits one full instruction cycle before the first trial starts. Software can abort a conversion by clearing GO. A second GO request made while a conversion is running has no effect.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset `sample_en` is 1 and `go_busy`, `adif`, `result` and `dac_code` are 0. A `go_set` pulse seen while sampling makes `sample_en` 0 and `go_busy` 1 in the next cycle.
- R2: In system-clock mode (`clk_sel` = 0) each conversion-clock period lasts 2, 8 or 32 clocks for `div_sel` 00, 01 or 1x. The whole conversion takes 10 periods, counted from the clock edge that takes GO to the edge that completes it. The divider and clock-mode selects are captured with GO, so later changes to them have no effect on a conversion already running.
- R3: Bits are resolved from bit 9 down to bit 0. The first trial code is 0x200. `cmp_in` = 1 means the input is at or above the trial code. At the end of each period the bit under trial is kept when `cmp_in` is 1 and cleared when it is 0, and the next lower bit is set.
- R4: In RC mode (`clk_sel` = 1) `dac_code` stays 0 for 4 clocks (one instruction cycle) after the GO edge before it becomes 0x200. After that, each `rc_tick` pulse ends one period, so the conversion takes 10 pulses.
- R5: Completion happens on a single clock edge. On that edge `result` takes the final code, `adif` goes to 1 and `go_busy` goes to 0. `adif` then stays at 1 until an `adif_clr` pulse.
- R6: `result` holds its previous value for the whole of a conversion.
- R7: After completion or abort, `sample_en` returns to 1 within 1 to 4 clocks, on the edge taken in the fourth instruction phase. Counting the edges after reset release as 1, 2, 3 and so on, these are the edges whose number is a multiple of 4.
- R8: A `go_set` pulse while `go_busy` is 1 is ignored: the running conversion keeps its length and its result.
- R9: A `go_clr` pulse while `go_busy` is 1 aborts the conversion. `go_busy` is 0 in the next cycle, `result` is unchanged and `adif` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_set | input | 1 | Software GO request, one-clock pulse |
| go_clr | input | 1 | Software clear of GO, one-clock pulse, aborts a conversion |
| clk_sel | input | 1 | Conversion clock source: 0 divided system clock, 1 RC oscillator |
| div_sel | input | 2 | System-clock divider select: 00 = /2, 01 = /8, 1x = /32 |
| rc_tick | input | 1 | One-clock pulse per RC oscillator period, already in the clk domain |
| cmp_in | input | 1 | Comparator: 1 when the held input is at or above the trial code |
| adif_clr | input | 1 | Clears the interrupt flag |
| sample_en | output | 1 | Hold capacitor connected to the input (sampling) |
| go_busy | output | 1 | GO/busy status, 1 while a conversion is running |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Last completed conversion result |
| adif | output | 1 | Conversion-complete interrupt flag |

## Verification
The bench builds the block with its default parameters: 10 result bits, a four-phase instruction cycle and dividers of 2, 8 and 32. With the divide-by-2 setting a full conversion takes only 20 clocks, so the bench can afford the extreme codes 0 and 1023, the midpoint neighbours 512 and 513, and checks of the period length at every divider select. The divide-by-32 setting is reached through both select codes 10 and 11. An RC pulse period of 5 clocks is not a multiple of the instruction cycle, so completions land on every instruction phase and the return to sampling is checked against phase 4 from several starting points.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      ST_SAMPLE = 2'd0,
      ST_RCWAIT = 2'd1,
      ST_CONV   = 2'd2,
      ST_HOLD   = 2'd3
   } seq_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sar_phase_ctr.sv
module sar_phase_ctr #(
   parameter int Q_PHASES = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic q_last
);
   localparam int QW = (Q_PHASES > 1) ? $clog2(Q_PHASES) : 1;
   localparam logic [QW-1:0] LAST_PH = QW'(Q_PHASES - 1);

   logic [QW-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (phase == LAST_PH) begin
         phase <= '0;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   assign q_last = (phase == LAST_PH);

endmodule

// File: rtl/sar_adclk_gen.sv
module sar_adclk_gen
   import sar_seq_pkg::*;
#(
   parameter int DIV_A = 2,
   parameter int DIV_B = 8,
   parameter int DIV_C = 32,
   parameter bit RC_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       use_rc,
   input  logic [1:0] dsel,
   input  logic       rc_tick,
   output logic       ad_tick
);
   localparam int DMAX = max3(DIV_A, DIV_B, DIV_C);
   localparam int CW   = (DMAX > 2) ? $clog2(DMAX) : 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          div_hit;

   always_comb begin
      case (dsel)
         2'b00:   lim = CW'(DIV_A - 1);
         2'b01:   lim = CW'(DIV_B - 1);
         default: lim = CW'(DIV_C - 1);
      endcase
   end

   assign div_hit = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || div_hit) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   generate
      if (RC_EN) begin : g_two_src
         assign ad_tick = run && (use_rc ? rc_tick : div_hit);
      end else begin : g_sys_only
         assign ad_tick = run && div_hit;
      end
   endgenerate

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
   parameter int RES_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic                tick,
   input  logic                cmp,
   output logic [RES_BITS-1:0] code,
   output logic [RES_BITS-1:0] res_next,
   output logic                done
);
   localparam int IW = $clog2(RES_BITS);
   localparam logic [IW-1:0] TOP_IDX = IW'(RES_BITS - 1);
   localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

   logic [IW-1:0]       idx;
   logic [RES_BITS-1:0] trial_next;

   always_comb begin
      res_next      = code;
      res_next[idx] = cmp;
      trial_next    = res_next;
      if (idx != '0) begin
         trial_next[idx - 1'b1] = 1'b1;
      end
      done = tick && (idx == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         idx  <= TOP_IDX;
      end else if (clr) begin
         code <= '0;
         idx  <= TOP_IDX;
      end else if (load) begin
         code <= MSB_ONLY;
         idx  <= TOP_IDX;
      end else if (tick) begin
         code <= trial_next;
         if (idx != '0) begin
            idx <= idx - 1'b1;
         end
      end
   end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter int RES_BITS = 10,
   parameter int Q_PHASES = 4,
   parameter int DIV_A    = 2,
   parameter int DIV_B    = 8,
   parameter int DIV_C    = 32,
   parameter bit RC_EN    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go_set,
   input  logic                go_clr,
   input  logic                clk_sel,
   input  logic [1:0]          div_sel,
   input  logic                rc_tick,
   input  logic                cmp_in,
   input  logic                adif_clr,
   output logic                sample_en,
   output logic                go_busy,
   output logic [RES_BITS-1:0] dac_code,
   output logic [RES_BITS-1:0] result,
   output logic                adif
);
   localparam int QW = (Q_PHASES > 1) ? $clog2(Q_PHASES) : 1;
   localparam logic [QW-1:0] WAIT_LAST = QW'(Q_PHASES - 1);

   generate
      if (RES_BITS < 2) begin : g_bad_res
         initial $fatal(1, "sar_conv_seq: RES_BITS must be at least 2");
      end
      if (Q_PHASES < 2) begin : g_bad_q
         initial $fatal(1, "sar_conv_seq: Q_PHASES must be at least 2");
      end
      if (DIV_A < 2 || DIV_B < 2 || DIV_C < 2) begin : g_bad_div
         initial $fatal(1, "sar_conv_seq: every divider must be at least 2");
      end
   endgenerate

   seq_state_t          state;
   logic [QW-1:0]       wcnt;
   logic                use_rc_q;
   logic [1:0]          dsel_q;
   logic                rc_req;
   logic                q4;
   logic                ad_tick;
   logic                eng_clr;
   logic                eng_load;
   logic                eng_done;
   logic                finish;
   logic [RES_BITS-1:0] eng_final;

   assign rc_req   = RC_EN && clk_sel;
   assign eng_clr  = (state == ST_SAMPLE) && go_set && rc_req;
   assign eng_load = ((state == ST_SAMPLE) && go_set && !rc_req) ||
                     ((state == ST_RCWAIT) && !go_clr && (wcnt == WAIT_LAST));
   assign finish   = (state == ST_CONV) && !go_clr && eng_done;

   sar_phase_ctr #(.Q_PHASES(Q_PHASES)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .q_last (q4)
   );

   sar_adclk_gen #(
      .DIV_A (DIV_A),
      .DIV_B (DIV_B),
      .DIV_C (DIV_C),
      .RC_EN (RC_EN)
   ) u_adclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_CONV),
      .use_rc  (use_rc_q),
      .dsel    (dsel_q),
      .rc_tick (rc_tick),
      .ad_tick (ad_tick)
   );

   sar_bit_engine #(.RES_BITS(RES_BITS)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (eng_clr),
      .load     (eng_load),
      .tick     (ad_tick),
      .cmp      (cmp_in),
      .code     (dac_code),
      .res_next (eng_final),
      .done     (eng_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SAMPLE;
         wcnt     <= '0;
         use_rc_q <= 1'b0;
         dsel_q   <= 2'b00;
         result   <= '0;
      end else begin
         case (state)
            ST_SAMPLE: begin
               if (go_set) begin
                  use_rc_q <= rc_req;
                  dsel_q   <= div_sel;
                  wcnt     <= '0;
                  state    <= rc_req ? ST_RCWAIT : ST_CONV;
               end
            end
            ST_RCWAIT: begin
               if (go_clr) begin
                  state <= ST_HOLD;
               end else if (wcnt == WAIT_LAST) begin
                  state <= ST_CONV;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            ST_CONV: begin
               if (go_clr) begin
                  state <= ST_HOLD;
               end else if (eng_done) begin
                  result <= eng_final;
                  state  <= ST_HOLD;
               end
            end
            default: begin
               if (q4) begin
                  state <= ST_SAMPLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adif <= 1'b0;
      end else if (finish) begin
         adif <= 1'b1;
      end else if (adif_clr) begin
         adif <= 1'b0;
      end
   end

   assign sample_en = (state == ST_SAMPLE);
   assign go_busy   = (state == ST_RCWAIT) || (state == ST_CONV);

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int RES_BITS = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_en,
   input logic                go_busy,
   input logic                go_clr,
   input logic                adif,
   input logic [RES_BITS-1:0] result,
   input logic [RES_BITS-1:0] dac_code,
   input logic                q4,
   input logic                use_rc
);
   localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

   AST_BUSY_HOLDS_OFF_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
      go_busy |-> !sample_en); // R1

   AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(go_busy) && !use_rc) |-> (dac_code == MSB_ONLY)); // R3

   AST_RC_START_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(go_busy) && use_rc) |-> (dac_code == '0)); // R4

   AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adif) |-> $fell(go_busy)); // R5

   AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> ($fell(go_busy) && adif)); // R6

   AST_RESAMPLE_ON_Q4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_en) |-> $past(q4)); // R7

   AST_ABORT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (go_busy && go_clr) |=> (!go_busy && !$rose(adif))); // R9

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sample_en (sample_en),
   .go_busy   (go_busy),
   .go_clr    (go_clr),
   .adif      (adif),
   .result    (result),
   .dac_code  (dac_code),
   .q4        (q4),
   .use_rc    (use_rc_q)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         go_set, go_clr, clk_sel, rc_tick, adif_clr;
   logic [1:0]   div_sel;
   logic         cmp_in;
   logic         sample_en, go_busy, adif;
   logic [W-1:0] dac_code, result;
   logic [W-1:0] vin;
   logic [W-1:0] last_res;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit adif_d = 1'b0;
   bit ended = 1'b0;

   typedef struct {
      logic [W-1:0] val;
      int           cycles;
      int           t0;
      string        tag;
   } exp_t;
   exp_t sb[$];
   exp_t cur;

   always #5 clk = ~clk;

   assign cmp_in = (vin >= dac_code);

   sar_conv_seq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_set    (go_set),
      .go_clr    (go_clr),
      .clk_sel   (clk_sel),
      .div_sel   (div_sel),
      .rc_tick   (rc_tick),
      .cmp_in    (cmp_in),
      .adif_clr  (adif_clr),
      .sample_en (sample_en),
      .go_busy   (go_busy),
      .dac_code  (dac_code),
      .result    (result),
      .adif      (adif)
   );

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: pops the scoreboard when the completion flag rises
   always @(negedge clk) begin
      if (rst_n && adif && !adif_d) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R5 unexpected flag", 1, 0);
         end else begin
            cur = sb.pop_front();
            chk(result == cur.val, cur.tag, int'(result), int'(cur.val));
            if (cur.cycles >= 0)
               chk(cyc - cur.t0 - 1 == cur.cycles, "R2 conversion length",
                   cyc - cur.t0 - 1, cur.cycles);
         end
      end
      adif_d <= adif;
   end

   // RC oscillator model: one pulse every 5 clocks
   initial begin
      rc_tick = 1'b0;
      forever begin
         repeat (4) @(posedge clk);
         #2 rc_tick = 1'b1;
         @(posedge clk);
         #2 rc_tick = 1'b0;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   task automatic pulse_go();
      go_set = 1'b1;
      @(negedge clk);
      go_set = 1'b0;
   endtask

   task automatic finish_conv(input logic [W-1:0] v);
      int k;
      while (!adif) @(negedge clk);
      chk(!go_busy && !sample_en, "R5 busy cleared at completion", go_busy, 0);
      last_res = v;
      k = 0;
      while (!sample_en) begin
         @(negedge clk);
         k++;
      end
      chk(k >= 1 && k <= 4, "R7 resample delay", k, 4);
      chk(cyc % 4 == 0, "R7 resample phase", cyc % 4, 0);
      chk(adif, "R5 flag held", adif, 1);
      adif_clr = 1'b1;
      @(negedge clk);
      adif_clr = 1'b0;
      chk(!adif, "R5 flag clear", adif, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic conv_sys(input logic [W-1:0] v, input logic [1:0] ds,
                           input bit extra_go, input string tag);
      int d;
      d = (ds == 2'b00) ? 2 : (ds == 2'b01) ? 8 : 32;
      vin = v;
      clk_sel = 1'b0;
      div_sel = ds;
      sb.push_back('{val: v, cycles: W * d, t0: cyc, tag: tag});
      pulse_go();
      chk(!sample_en && go_busy, "R1 start", sample_en, 0);
      chk(dac_code == 10'h200, "R3 first trial", int'(dac_code), 512);
      div_sel = ~ds;   // R2: ignored after capture
      clk_sel = 1'b1;
      if (ds == 2'b01) begin
         repeat (8) @(negedge clk);
         chk(dac_code == ((v >= 10'd512) ? 10'h300 : 10'h100), "R3 second trial",
             int'(dac_code), (v >= 10'd512) ? 768 : 256);
      end
      repeat (3) @(negedge clk);
      chk(result == last_res, "R6 result held", int'(result), int'(last_res));
      if (extra_go) begin
         pulse_go();
         chk(go_busy, "R8 busy after second GO", go_busy, 1);
      end
      finish_conv(v);
   endtask

   task automatic conv_rc(input logic [W-1:0] v);
      int ticks;
      vin = v;
      clk_sel = 1'b1;
      div_sel = 2'b00;
      sb.push_back('{val: v, cycles: -1, t0: cyc, tag: "R4 rc result"});
      pulse_go();
      for (int i = 0; i < 4; i++) begin
         chk(dac_code == '0 && go_busy, "R4 start delay", int'(dac_code), 0);
         @(negedge clk);
      end
      chk(dac_code == 10'h200, "R4 first trial after delay", int'(dac_code), 512);
      ticks = 0;
      while (!adif) begin
         if (rc_tick) ticks++;
         @(negedge clk);
      end
      chk(ticks == W, "R4 rc periods", ticks, W);
      finish_conv(v);
   endtask

   task automatic conv_abort(input logic [W-1:0] v, input logic rc);
      int seen;
      vin = v;
      clk_sel = rc;
      div_sel = 2'b01;
      pulse_go();
      repeat (6) @(negedge clk);
      chk(go_busy, "R9 running before abort", go_busy, 1);
      go_clr = 1'b1;
      @(negedge clk);
      go_clr = 1'b0;
      chk(!go_busy, "R9 busy cleared", go_busy, 0);
      seen = 0;
      for (int i = 0; i < 60; i++) begin
         if (adif) seen++;
         @(negedge clk);
      end
      chk(seen == 0, "R9 no flag", seen, 0);
      chk(result == last_res, "R9 result kept", int'(result), int'(last_res));
      chk(sample_en, "R7 sampling after abort", sample_en, 1);
   endtask

   initial begin
      rst_n = 1'b0;
      go_set = 1'b0;
      go_clr = 1'b0;
      clk_sel = 1'b0;
      div_sel = 2'b00;
      adif_clr = 1'b0;
      vin = '0;
      last_res = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sample_en && !go_busy && !adif, "R1 reset state", sample_en, 1);
      chk(result == '0 && dac_code == '0, "R1 reset codes", int'(result), 0);

      conv_sys(10'd0,    2'b00, 1'b0, "R2 zero /2");
      conv_sys(10'd1023, 2'b00, 1'b0, "R2 full /2");
      conv_sys(10'd300,  2'b01, 1'b0, "R3 walk /8");
      conv_sys(10'd777,  2'b01, 1'b0, "R3 upper /8");
      conv_sys(10'd512,  2'b10, 1'b0, "R2 mid /32");
      conv_sys(10'd513,  2'b11, 1'b0, "R2 mid+1 /32 alt");
      conv_sys(10'd341,  2'b00, 1'b1, "R8 ignored GO");
      conv_rc(10'd645);
      conv_rc(10'd1);
      conv_abort(10'd100, 1'b0);
      conv_abort(10'd200, 1'b1);
      conv_sys(10'd682,  2'b01, 1'b0, "R6 after abort");
      chk(sb.size() == 0, "R5 all completions seen", sb.size(), 0);
      summary();
   end

endmodule